// File: doc/BRIEF.md
# Register Status Table with Renaming Tags

This block keeps one row per architectural register and tells the issue logic where the newest value of that register lives. A row is either valid, meaning the register file already holds the latest value, or busy, meaning an in-flight instruction will produce the value. A busy row also names the reorder-buffer slot that holds, or will hold, the value. Operand fetch reads this table first. It indexes the reorder buffer with the returned tag only when the row is busy, so the buffer never needs an associative search by register number.

At decode, the rename port points a destination register at the freshly allocated buffer slot. A later writer of the same register simply overwrites the tag, so readers always see the youngest producer, and write-after-read and write-after-write conflicts disappear. When a slot retires, the commit port returns the row to valid, but only if that slot is still the row's owner. A flush returns every row to valid. The table stores no data values.

Top module: `reg_status_table`

## Requirements
- R1: After reset every register reads valid: busy output 0 and tag output 0.
- R2: Each of the two lookup ports answers combinationally in the same cycle. For a busy register it returns busy=1 and the owning tag. For a valid register it returns busy=0 and tag 0.
- R3: A rename of register r (r not 0) with tag t makes r read busy with tag t from the next cycle on. A later rename of r replaces the tag, so the youngest writer wins.
- R4: A commit of tag t for register r returns r to valid in the next cycle, provided r is busy and its current tag equals t.
- R5: A commit whose tag differs from the register's current tag, or that targets a valid register, leaves that row unchanged.
- R6: When a rename and a commit name the same register in the same cycle, the rename takes effect and the commit is dropped.
- R7: A lookup made in the same cycle as a rename of that register returns the mapping from before the rename.
- R8: Flush makes every register valid in the next cycle. It overrides any rename or commit presented in the same cycle.
- R9: Register 0 always reads valid. A rename of register 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Return all rows to valid |
| ren_en | input | 1 | Rename request |
| ren_reg | input | REG_W | Destination register being renamed |
| ren_tag | input | TAG_W | Newly allocated buffer slot |
| cmt_en | input | 1 | Commit request |
| cmt_reg | input | REG_W | Destination register of retiring slot |
| cmt_tag | input | TAG_W | Retiring buffer slot |
| rd_a_reg | input | REG_W | Lookup port A register |
| rd_a_busy | output | 1 | Port A: value pending in buffer |
| rd_a_tag | output | TAG_W | Port A: owning slot, 0 when valid |
| rd_b_reg | input | REG_W | Lookup port B register |
| rd_b_busy | output | 1 | Port B: value pending in buffer |
| rd_b_tag | output | TAG_W | Port B: owning slot, 0 when valid |

## Verification
The bench targets a stale commit arriving after the register was renamed again. A design that compares only the register number would wrongly mark the row valid, and readers would then take an old value from the register file. It also presents a rename and a commit to the same register in one cycle, where a wrong priority loses the new mapping. It looks up a register in the same cycle it is renamed, where a forwarding design would return the new tag too early. It sends flushes together with renames, and renames of register 0, which must never appear busy. A long stretch of random traffic over a handful of registers drives these collisions constantly.

// File: rtl/reg_status_table.sv
module reg_status_table #(
  parameter int NUM_REGS  = 32,
  parameter int ROB_DEPTH = 16,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(ROB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ren_en,
  input  logic [REG_W-1:0] ren_reg,
  input  logic [TAG_W-1:0] ren_tag,
  input  logic             cmt_en,
  input  logic [REG_W-1:0] cmt_reg,
  input  logic [TAG_W-1:0] cmt_tag,
  input  logic [REG_W-1:0] rd_a_reg,
  output logic             rd_a_busy,
  output logic [TAG_W-1:0] rd_a_tag,
  input  logic [REG_W-1:0] rd_b_reg,
  output logic             rd_b_busy,
  output logic [TAG_W-1:0] rd_b_tag
);

  logic [NUM_REGS-1:0]            busy_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0] tag_vec;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    if (r == 0) begin : g_zero
      assign busy_vec[r] = 1'b0;
      assign tag_vec[r]  = '0;
    end else begin : g_live
      logic             busy_q;
      logic [TAG_W-1:0] tag_q;
      wire ren_hit = ren_en && (ren_reg == REG_W'(r));
      wire cmt_hit = cmt_en && (cmt_reg == REG_W'(r)) && busy_q && (tag_q == cmt_tag);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q <= 1'b0;
          tag_q  <= '0;
        end else if (flush) begin
          busy_q <= 1'b0;
        end else if (ren_hit) begin
          busy_q <= 1'b1;
          tag_q  <= ren_tag;
        end else if (cmt_hit) begin
          busy_q <= 1'b0;
        end
      end

      assign busy_vec[r] = busy_q;
      assign tag_vec[r]  = tag_q;
    end
  end

  assign rd_a_busy = busy_vec[rd_a_reg];
  assign rd_a_tag  = rd_a_busy ? tag_vec[rd_a_reg] : '0;
  assign rd_b_busy = busy_vec[rd_b_reg];
  assign rd_b_tag  = rd_b_busy ? tag_vec[rd_b_reg] : '0;

  // R3 R6
  rename_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_en && ren_reg != '0 && !flush)
    |=> (busy_vec[$past(ren_reg)] && tag_vec[$past(ren_reg)] == $past(ren_tag)));

  // R4
  commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en && !flush && !(ren_en && ren_reg == cmt_reg) &&
     busy_vec[cmt_reg] && tag_vec[cmt_reg] == cmt_tag)
    |=> !busy_vec[$past(cmt_reg)]);

  // R5
  stale_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en && !flush && !(ren_en && ren_reg == cmt_reg) &&
     !(busy_vec[cmt_reg] && tag_vec[cmt_reg] == cmt_tag))
    |=> (busy_vec[$past(cmt_reg)] == $past(busy_vec[cmt_reg]) &&
         tag_vec[$past(cmt_reg)] == $past(tag_vec[cmt_reg])));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));

  // R9
  zero_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_reg == '0) |-> (!rd_a_busy && rd_a_tag == '0));

endmodule

// File: tb/tb_reg_status_table.sv
`timescale 1ns/1ps
module tb_reg_status_table;
  localparam int NR = 32;
  localparam int ND = 16;
  localparam int RW = $clog2(NR);
  localparam int TW = $clog2(ND);

  logic clk = 0, rst_n = 0;
  logic flush = 0, ren_en = 0, cmt_en = 0;
  logic [RW-1:0] ren_reg = 0, cmt_reg = 0, rd_a_reg = 0, rd_b_reg = 0;
  logic [TW-1:0] ren_tag = 0, cmt_tag = 0;
  logic rd_a_busy, rd_b_busy;
  logic [TW-1:0] rd_a_tag, rd_b_tag;

  always #2.5 clk = ~clk;

  reg_status_table #(.NUM_REGS(NR), .ROB_DEPTH(ND)) dut (.*);

  int m_busy[NR];
  int m_tag[NR];
  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string lbl, int act_b, int act_t, int reg_i);
    int eb = m_busy[reg_i];
    int et = eb ? m_tag[reg_i] : 0;
    n_chk++;
    if (act_b != eb || act_t != et) begin
      n_fail++;
      $display("FAIL %s reg %0d: busy/tag actual %0d/%0d expected %0d/%0d",
               lbl, reg_i, act_b, act_t, eb, et);
    end
  endtask

  task automatic step(string lbl, bit fl, bit re, int rr, int rt,
                      bit ce, int cr, int ct, int la, int lb);
    @(negedge clk);
    flush = fl; ren_en = re; ren_reg = RW'(rr); ren_tag = TW'(rt);
    cmt_en = ce; cmt_reg = RW'(cr); cmt_tag = TW'(ct);
    rd_a_reg = RW'(la); rd_b_reg = RW'(lb);
    #1;
    check(lbl, int'(rd_a_busy), int'(rd_a_tag), la);
    check(lbl, int'(rd_b_busy), int'(rd_b_tag), lb);
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < NR; i++) m_busy[i] = 0;
    end else if (re && rr != 0) begin
      m_busy[rr] = 1; m_tag[rr] = rt;
      if (ce && cr != rr && m_busy[cr] == 1 && m_tag[cr] == ct) m_busy[cr] = 0;
    end else if (ce && m_busy[cr] == 1 && m_tag[cr] == ct) begin
      m_busy[cr] = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin m_busy[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NR; i += 2) step("R1 reset", 0, 0, 0, 0, 0, 0, 0, i, i + 1);
    step("R7 same-cycle lookup", 0, 1, 5, 3, 0, 0, 0, 5, 0);
    step("R3 rename visible", 0, 0, 0, 0, 0, 0, 0, 5, 6);
    step("R3 second rename", 0, 1, 5, 7, 0, 0, 0, 5, 5);
    step("R3 youngest wins", 0, 0, 0, 0, 0, 0, 0, 5, 5);
    step("R5 stale commit", 0, 0, 0, 0, 1, 5, 3, 5, 5);
    step("R5 after stale commit", 0, 0, 0, 0, 0, 0, 0, 5, 5);
    step("R4 owning commit", 0, 0, 0, 0, 1, 5, 7, 5, 5);
    step("R4 after commit", 0, 0, 0, 0, 0, 0, 0, 5, 5);
    step("R5 commit to valid", 0, 0, 0, 0, 1, 5, 7, 5, 6);
    step("R6 setup", 0, 1, 6, 1, 0, 0, 0, 6, 5);
    step("R6 rename+commit", 0, 1, 6, 2, 1, 6, 1, 6, 5);
    step("R6 rename kept", 0, 0, 0, 0, 0, 0, 0, 6, 6);
    step("R9 rename zero", 0, 1, 0, 9, 0, 0, 0, 0, 6);
    step("R9 zero after", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 setup", 0, 1, 9, 4, 0, 0, 0, 9, 6);
    step("R8 flush with rename", 1, 1, 10, 5, 1, 9, 4, 9, 10);
    step("R8 after flush", 0, 0, 0, 0, 0, 0, 0, 9, 10);
    step("R8 after flush b", 0, 0, 0, 0, 0, 0, 0, 6, 5);
    for (int n = 0; n < 4000; n++) begin
      int rr = $urandom_range(0, 7);
      int cr = $urandom_range(0, 7);
      int ct = ($urandom_range(0, 3) != 0 && m_busy[cr] == 1) ? m_tag[cr]
               : int'($urandom_range(0, ND - 1));
      step("R2 random", ($urandom_range(0, 63) == 0), ($urandom_range(0, 1) == 1), rr,
           int'($urandom_range(0, ND - 1)), ($urandom_range(0, 1) == 1), cr, ct,
           int'($urandom_range(0, 8)), int'($urandom_range(0, NR - 1)));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule